// File: doc/BRIEF.md
# Fetch Thread Selector

This block decides, every cycle, which hardware thread of a multithreaded core may use the instruction fetch path. Each thread reports its fetch state as a small code. The block works out from these codes which threads can fetch. It then picks one of them under a policy chosen at run time. The grant is combinational: `grant_valid_o` and `grant_tid_o` follow the inputs within the same cycle.

There are four policies. The first serves only thread 0. The second is a rotating priority list in which the thread that was served goes to the back. The last two favour the thread that has the fewest entries in the instruction queue or in the load/store queue. The fetch unit pulses `consume_i` in a cycle where it actually uses the grant. Only such a pulse, in rotating mode, changes the priority list. Selecting the single-thread policy in a configuration with several threads is reported on `cfg_err_o`.

Top module: `fetch_thread_sel`

## Requirements
- R1: A thread is eligible only when its 3-bit state code is 0 (running), 1 (idle) or 2 (line fetch done). Codes 3 to 7 (blocked, squashing, waiting for response, waiting for retry, reserved) are never granted.
- R2: With `policy_i` = 2'b00 (single), the grant is thread 0 whenever thread 0 is eligible and is invalid otherwise. The other threads have no effect.
- R3: With `policy_i` = 2'b01 (rotate), the grant goes to the first eligible thread in a priority list. The list holds thread ids 0,1,..,N-1 in that order after reset.
- R4: A cycle with a valid rotate grant and `consume_i` high moves the granted thread to the tail of the list. The other threads keep their relative order.
- R5: The list is unchanged in any cycle where `consume_i` is low, or where the policy is not rotate.
- R6: With `policy_i` = 2'b10, the grant goes to the eligible thread with the smallest instruction-queue count. A tie goes to the lower thread id.
- R7: With `policy_i` = 2'b11, the grant goes to the eligible thread with the smallest load/store-queue count. A tie goes to the lower thread id. Instruction-queue counts are ignored in this mode.
- R8: When no thread is eligible, `grant_valid_o` is 0 and `grant_tid_o` is 0.
- R9: `cfg_err_o` is 1 exactly when the policy is single and more than one thread is configured.
- R10: With one thread configured, thread 0 is granted whenever it is eligible, under every policy, and `cfg_err_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| status_i | input | 3*NUM_THREADS | Per-thread state code; thread i occupies bits [3i+2:3i] |
| iq_cnt_i | input | CNT_W*NUM_THREADS | Per-thread instruction-queue occupancy |
| lsq_cnt_i | input | CNT_W*NUM_THREADS | Per-thread load/store-queue occupancy |
| policy_i | input | 2 | Selection policy code |
| consume_i | input | 1 | Grant used this cycle |
| grant_valid_o | output | 1 | A thread is granted |
| grant_tid_o | output | TID_W | Granted thread id |
| cfg_err_o | output | 1 | Single policy used with several threads |

## Verification
The hardest state to reach is a priority list that is no longer in id order and has a thread partly blocked. Only a chain of consumed rotate grants, interleaved with eligibility changes, builds such a list. The bench consumes grants step by step and blocks one thread midway, which yields the order 2,0,1,3. It then pulses `consume_i` under other policies and checks that the rotate grant still reflects that order. A second instance with a single thread covers R10.

// File: rtl/fts_pkg.sv
package fts_pkg;
  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_RUN       = 3'd0,
    ST_IDLE      = 3'd1,
    ST_LINE_DONE = 3'd2,
    ST_BLOCKED   = 3'd3,
    ST_SQUASH    = 3'd4,
    ST_WAIT_RESP = 3'd5,
    ST_WAIT_RTRY = 3'd6,
    ST_RSVD      = 3'd7
  } fetch_state_e;

  typedef enum logic [1:0] {
    POL_SINGLE = 2'd0,
    POL_ROTATE = 2'd1,
    POL_IQ     = 2'd2,
    POL_LSQ    = 2'd3
  } sel_policy_e;
endpackage

// File: rtl/fts_elig.sv
module fts_elig
  import fts_pkg::*;
#(
  parameter int NUM_THREADS = 4
) (
  input  logic [NUM_THREADS*STATE_W-1:0] status_i,
  output logic [NUM_THREADS-1:0]         elig_o
);
  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    fetch_state_e st;
    assign st = fetch_state_e'(status_i[t*STATE_W +: STATE_W]);
    assign elig_o[t] = (st == ST_RUN) || (st == ST_IDLE) || (st == ST_LINE_DONE);
  end
endmodule

// File: rtl/fts_min_pick.sv
module fts_min_pick #(
  parameter int NUM_THREADS = 4,
  parameter int CNT_W       = 6,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic [NUM_THREADS-1:0]       elig_i,
  input  logic [NUM_THREADS*CNT_W-1:0] cnt_i,
  output logic                         valid_o,
  output logic [TID_W-1:0]             tid_o
);
  logic [CNT_W-1:0] best_cnt;

  // strict compare keeps the lowest id on ties
  always_comb begin
    valid_o  = 1'b0;
    tid_o    = '0;
    best_cnt = '0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      if (elig_i[t] && (!valid_o || cnt_i[t*CNT_W +: CNT_W] < best_cnt)) begin
        valid_o  = 1'b1;
        tid_o    = TID_W'(t);
        best_cnt = cnt_i[t*CNT_W +: CNT_W];
      end
    end
  end
endmodule

// File: rtl/fts_rr_list.sv
module fts_rr_list #(
  parameter int NUM_THREADS = 4,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_THREADS-1:0] elig_i,
  input  logic                   upd_i,
  output logic                   valid_o,
  output logic [TID_W-1:0]       tid_o
);
  logic [NUM_THREADS-1:0][TID_W-1:0] list_q, list_d;
  logic [TID_W-1:0]                  pos;

  always_comb begin
    valid_o = 1'b0;
    pos     = '0;
    for (int k = 0; k < NUM_THREADS; k++) begin
      if (!valid_o && elig_i[list_q[k]]) begin
        valid_o = 1'b1;
        pos     = TID_W'(k);
      end
    end
  end

  assign tid_o = list_q[pos];

  // entries behind the winner slide forward, winner goes to the tail
  for (genvar k = 0; k < NUM_THREADS - 1; k++) begin : g_shift
    assign list_d[k] = (TID_W'(k) < pos) ? list_q[k] : list_q[k+1];
  end
  assign list_d[NUM_THREADS-1] = list_q[pos];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NUM_THREADS; k++) list_q[k] <= TID_W'(k);
    end else if (upd_i) begin
      list_q <= list_d;
    end
  end

  logic [NUM_THREADS-1:0] seen;
  always_comb begin
    seen = '0;
    for (int k = 0; k < NUM_THREADS; k++) seen[list_q[k]] = 1'b1;
  end

  // R3
  rr_perm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) &seen);

  // R4
  rr_tail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> list_q[NUM_THREADS-1] == $past(tid_o));
endmodule

// File: rtl/fetch_thread_sel.sv
module fetch_thread_sel
  import fts_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int CNT_W       = 6,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_THREADS*STATE_W-1:0] status_i,
  input  logic [NUM_THREADS*CNT_W-1:0] iq_cnt_i,
  input  logic [NUM_THREADS*CNT_W-1:0] lsq_cnt_i,
  input  logic [1:0]                   policy_i,
  input  logic                         consume_i,
  output logic                         grant_valid_o,
  output logic [TID_W-1:0]             grant_tid_o,
  output logic                         cfg_err_o
);
  logic [NUM_THREADS-1:0] elig;
  sel_policy_e            pol;

  assign pol = sel_policy_e'(policy_i);

  fts_elig #(.NUM_THREADS(NUM_THREADS)) u_elig (
    .status_i (status_i),
    .elig_o   (elig)
  );

  if (NUM_THREADS == 1) begin : g_one
    logic unused_in;
    assign unused_in     = ^{clk_i, rst_ni, iq_cnt_i, lsq_cnt_i, pol, consume_i};
    assign grant_valid_o = elig[0];
    assign grant_tid_o   = '0;
    assign cfg_err_o     = 1'b0;
  end else begin : g_multi
    logic [NUM_THREADS*CNT_W-1:0] occ;
    logic                         min_valid, rr_valid;
    logic [TID_W-1:0]             min_tid, rr_tid;

    assign occ = (pol == POL_LSQ) ? lsq_cnt_i : iq_cnt_i;

    fts_min_pick #(.NUM_THREADS(NUM_THREADS), .CNT_W(CNT_W)) u_min (
      .elig_i  (elig),
      .cnt_i   (occ),
      .valid_o (min_valid),
      .tid_o   (min_tid)
    );

    fts_rr_list #(.NUM_THREADS(NUM_THREADS)) u_rr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .elig_i  (elig),
      .upd_i   (consume_i && (pol == POL_ROTATE) && rr_valid),
      .valid_o (rr_valid),
      .tid_o   (rr_tid)
    );

    always_comb begin
      grant_valid_o = 1'b0;
      grant_tid_o   = '0;
      unique case (pol)
        POL_SINGLE: grant_valid_o = elig[0];
        POL_ROTATE: begin
          grant_valid_o = rr_valid;
          grant_tid_o   = rr_valid ? rr_tid : '0;
        end
        default: begin
          grant_valid_o = min_valid;
          grant_tid_o   = min_valid ? min_tid : '0;
        end
      endcase
    end

    assign cfg_err_o = (pol == POL_SINGLE);

    logic min_ok;
    always_comb begin
      min_ok = 1'b1;
      if (grant_valid_o && (pol == POL_IQ || pol == POL_LSQ)) begin
        for (int t = 0; t < NUM_THREADS; t++) begin
          if (elig[t] &&
              ((occ[t*CNT_W +: CNT_W] < occ[grant_tid_o*CNT_W +: CNT_W]) ||
               (occ[t*CNT_W +: CNT_W] == occ[grant_tid_o*CNT_W +: CNT_W] &&
                TID_W'(t) < grant_tid_o)))
            min_ok = 1'b0;
        end
      end
    end

    // R6
    min_pick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) min_ok);

    // R2
    single_tid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pol == POL_SINGLE) |-> (grant_tid_o == '0));
  end

  // R1
  grant_elig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |-> elig[grant_tid_o]);

  // R8
  no_elig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (elig == '0) |-> (!grant_valid_o && grant_tid_o == '0));
endmodule

// File: tb/test_fetch_thread_sel.sv
module test_fetch_thread_sel;
  localparam int N  = 4;
  localparam int CW = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N*3-1:0]  status_i = '0;
  logic [N*CW-1:0] iq_cnt_i = '0;
  logic [N*CW-1:0] lsq_cnt_i = '0;
  logic [1:0]    policy_i = 2'd1;
  logic          consume_i = 1'b0;
  logic          grant_valid_o;
  logic [1:0]    grant_tid_o;
  logic          cfg_err_o;

  logic [2:0]    o_status = '0;
  logic [CW-1:0] o_iq = '0;
  logic [CW-1:0] o_lsq = '0;
  logic [1:0]    o_pol = '0;
  logic          o_valid, o_err;
  logic [0:0]    o_tid;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #2 clk_i = ~clk_i;

  fetch_thread_sel #(.NUM_THREADS(N), .CNT_W(CW)) i_fetch_thread_sel (
    .clk_i, .rst_ni, .status_i, .iq_cnt_i, .lsq_cnt_i, .policy_i, .consume_i,
    .grant_valid_o, .grant_tid_o, .cfg_err_o
  );

  fetch_thread_sel #(.NUM_THREADS(1), .CNT_W(CW)) i_one (
    .clk_i, .rst_ni, .status_i(o_status), .iq_cnt_i(o_iq), .lsq_cnt_i(o_lsq),
    .policy_i(o_pol), .consume_i, .grant_valid_o(o_valid), .grant_tid_o(o_tid),
    .cfg_err_o(o_err)
  );

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_st(input logic [2:0] s3, s2, s1, s0);
    status_i = {s3, s2, s1, s0};
  endtask

  // valid and tid checked together
  task automatic chk_grant(string req, int v, int tid);
    #1;
    check({req, " valid"}, grant_valid_o, v);
    check({req, " tid"}, grant_tid_o, tid);
  endtask

  task automatic consume_cycle();
    @(negedge clk_i) consume_i = 1'b1;
    @(negedge clk_i) consume_i = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    set_st(0, 0, 0, 0); policy_i = 2'd1;
    chk_grant("R3 reset order", 1, 0);
    check("R9 rotate no err", cfg_err_o, 0);
  endtask

  task automatic t_elig();
    @(negedge clk_i);
    set_st(3'd1, 3'd5, 3'd4, 3'd3);
    chk_grant("R1 idle eligible", 1, 3);
    @(negedge clk_i);
    set_st(3'd6, 3'd2, 3'd4, 3'd3);
    chk_grant("R1 line done eligible", 1, 2);
    @(negedge clk_i);
    set_st(3'd0, 3'd0, 3'd0, 3'd7);
    chk_grant("R1 reserved blocked", 1, 1);
  endtask

  task automatic t_none();
    @(negedge clk_i);
    set_st(3'd6, 3'd5, 3'd3, 3'd7);
    chk_grant("R8 rotate none", 0, 0);
    policy_i = 2'd2;
    chk_grant("R8 iq none", 0, 0);
    policy_i = 2'd1;
  endtask

  task automatic t_single();
    @(negedge clk_i);
    policy_i = 2'd0; set_st(0, 0, 0, 0);
    chk_grant("R2 thread0", 1, 0);
    check("R9 single err", cfg_err_o, 1);
    @(negedge clk_i);
    set_st(0, 0, 0, 3'd3);
    chk_grant("R2 thread0 blocked", 0, 0);
    consume_cycle();
  endtask

  task automatic t_rr();
    @(negedge clk_i);
    policy_i = 2'd1; set_st(0, 0, 0, 0);
    chk_grant("R5 list kept after single consume", 1, 0);
    consume_cycle();
    chk_grant("R4 after first consume", 1, 1);
    consume_cycle();
    chk_grant("R4 after second consume", 1, 2);
    set_st(0, 3'd3, 0, 0);
    chk_grant("R3 skip blocked", 1, 3);
    consume_cycle();
    set_st(0, 0, 0, 0);
    chk_grant("R4 list 2013", 1, 2);
  endtask

  task automatic t_rr_hold();
    @(negedge clk_i);
    consume_i = 1'b0;
    @(negedge clk_i);
    chk_grant("R5 no consume", 1, 2);
    policy_i = 2'd2;
    consume_cycle();
    policy_i = 2'd1;
    chk_grant("R5 other mode consume", 1, 2);
    set_st(0, 3'd3, 0, 0);
    chk_grant("R4 order kept 2013", 1, 0);
  endtask

  task automatic t_iq();
    @(negedge clk_i);
    policy_i = 2'd2; set_st(0, 0, 0, 0);
    iq_cnt_i  = {4'd9, 4'd3, 4'd3, 4'd5};
    lsq_cnt_i = {4'd0, 4'd0, 4'd0, 4'd0};
    chk_grant("R6 tie low id", 1, 1);
    set_st(0, 0, 3'd3, 0);
    chk_grant("R6 skip blocked", 1, 2);
    set_st(0, 3'd3, 3'd3, 0);
    chk_grant("R6 lowest eligible", 1, 0);
  endtask

  task automatic t_lsq();
    @(negedge clk_i);
    policy_i = 2'd3; set_st(0, 0, 0, 0);
    iq_cnt_i  = {4'd0, 4'd0, 4'd0, 4'd0};
    lsq_cnt_i = {4'd1, 4'd1, 4'd7, 4'd2};
    chk_grant("R7 tie low id", 1, 2);
    set_st(0, 3'd3, 0, 0);
    chk_grant("R7 skip blocked", 1, 3);
    check("R9 lsq no err", cfg_err_o, 0);
  endtask

  task automatic t_one();
    @(negedge clk_i);
    o_pol = 2'd0; o_status = 3'd0; o_iq = 4'd9; o_lsq = 4'd9;
    #1;
    check("R10 single valid", o_valid, 1);
    check("R10 tid", o_tid, 0);
    check("R10 no err", o_err, 0);
    @(negedge clk_i);
    o_pol = 2'd1; o_status = 3'd3;
    #1 check("R10 blocked", o_valid, 0);
    @(negedge clk_i);
    o_pol = 2'd3; o_status = 3'd1;
    #1 check("R10 lsq idle", o_valid, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_elig();
    t_none();
    t_single();
    t_rr();
    t_rr_hold();
    t_iq();
    t_lsq();
    t_one();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #40000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule